// File: doc/BRIEF.md
# Immediate Augmentation Prefix Unit

This decode-stage unit widens 9-bit immediate operands to full 32-bit values. Two prefix instructions exist, one aimed at the source operand and one at the destination operand. Each prefix carries a 23-bit payload, which is held in its own queue register with a pending flag. The next executing instruction that takes an immediate in the matching operand field receives the payload as bits 31..9 of that operand. Its own 9-bit field supplies bits 8..0. The pending flag is cleared at that point.

Instructions that do not take an immediate in a given field leave that field's queue untouched, so a pending payload survives any number of unrelated instructions. Execution is decided inside the unit from the instruction's 4-bit condition field, two flag inputs and a skip input. An instruction that does not execute neither loads nor consumes a queue. The condition code that also requests a return after the instruction is treated as an always-execute code, so such an instruction still applies and consumes its augmentation.

Every result is registered and appears one clock after the instruction is presented.

Top module: `imm_aug_unit`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and both queues are empty. An immediate consumer issued right after reset therefore sees zeros in bits 31..9.
- R2: A word is a prefix when bits 27..24 are 4'b1111. Bit 23 picks the queue (0 = source, 1 = destination) and bits 22..0 are the payload. An executing prefix loads the payload, sets the pending flag and reports `out_is_prefix` = 1. Its operand outputs follow the register rule of R11.
- R3: A non-prefix word with bit 18 set takes a source immediate from bits 8..0. `out_src` is {queued payload, bits 8..0} when the source queue is pending, else {23'b0, bits 8..0}. Executing it empties the source queue.
- R4: A non-prefix word with bit 19 set takes a destination immediate from bits 17..9. `out_dst` is {queued payload, bits 17..9} when the destination queue is pending, else zero-extended. Executing it empties the destination queue.
- R5: An instruction that does not take an immediate in a field leaves that field's queue pending and its payload unchanged. This covers register-operand instructions and instructions that only take the other kind of immediate.
- R6: Both queues can be pending together. A word with both bits 18 and 19 set receives and consumes both payloads in one instruction.
- R7: A second prefix of the same kind issued before consumption replaces the queued payload.
- R8: An instruction executes when its condition passes and `in_skip` is 0. The condition passes when bits 31..28 equal 4'b0000, or when bit {in_c,in_z} (a 2-bit index) of bits 31..28 is 1. `out_exec` reports the result.
- R9: An instruction that is cancelled by its condition or by `in_skip` consumes no queue, although its operand output still shows the pending augmentation. A cancelled prefix loads nothing.
- R10: Condition code 4'b0000 means execute always and then return. It gives `out_ret` = 1, and the instruction still applies and consumes its augmentation.
- R11: An operand field without the immediate flag is output zero-extended as {23'b0, field}.
- R12: Each presented instruction (`in_valid` = 1) produces exactly one result with `out_valid` = 1 on the next clock. Idle cycles produce `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 32 | Instruction word |
| in_c | input | 1 | Carry flag used by the condition |
| in_z | input | 1 | Zero flag used by the condition |
| in_skip | input | 1 | Instruction is being skipped |
| out_valid | output | 1 | Registered result valid |
| out_exec | output | 1 | Instruction executes |
| out_ret | output | 1 | Return requested after the instruction |
| out_is_prefix | output | 1 | Instruction was an augmentation prefix |
| out_src | output | 32 | Formed source operand |
| out_dst | output | 32 | Formed destination operand |

## Verification
The checker watches several rules on every cycle:
- the one-cycle result latency;
- that the low 9 bits of a source immediate pass through unchanged, and that the high bits equal the payload that was queued;
- that a non-consuming instruction keeps the source queue pending;
- that an executing consumer empties the source queue and a cancelled one does not;
- that a skipped instruction never executes;
- that the return code always executes when not skipped.

The scenarios show what a single cycle cannot:
- a payload surviving unrelated instructions;
- overwrite by a second prefix;
- a combined source and destination consumption;
- a cancelled prefix leaving no trace;
- the condition truth table under different flag values.

// File: rtl/imm_aug_pkg.sv
package imm_aug_pkg;
  localparam int WORD_W  = 32;
  localparam int IMM_W   = 9;
  localparam int AUG_W   = WORD_W - IMM_W;
  localparam int COND_W  = 4;
  localparam int TAG_W   = 4;
  localparam int N_KIND  = 2;

  // Field positions derived from the widths above
  localparam int S_LO     = 0;
  localparam int D_LO     = IMM_W;
  localparam int SIMM_BIT = 2 * IMM_W;
  localparam int DIMM_BIT = 2 * IMM_W + 1;
  localparam int KIND_BIT = AUG_W;
  localparam int TAG_LO   = AUG_W + 1;
  localparam int COND_LO  = WORD_W - COND_W;

  localparam logic [TAG_W-1:0]  PFX_TAG  = '1;
  localparam logic [COND_W-1:0] COND_RET = '0;

  typedef enum logic {KIND_SRC = 1'b0, KIND_DST = 1'b1} aug_kind_e;
endpackage

// File: rtl/imm_aug_cond.sv
module imm_aug_cond
  import imm_aug_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              c_flag,
  input  logic              z_flag,
  input  logic              skip,
  output logic              exec,
  output logic              ret
);
  logic ret_code;
  logic table_hit;

  always_comb begin
    ret_code  = (cond == COND_RET);
    table_hit = cond[{c_flag, z_flag}];
    exec      = (ret_code || table_hit) && !skip;
    ret       = ret_code;
  end
endmodule

// File: rtl/imm_aug_decode.sv
module imm_aug_decode
  import imm_aug_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  output logic              is_prefix,
  output aug_kind_e         pfx_kind,
  output logic [AUG_W-1:0]  payload,
  output logic [N_KIND-1:0] use_imm,
  output logic [IMM_W-1:0]  field_s,
  output logic [IMM_W-1:0]  field_d
);
  always_comb begin
    is_prefix = (insn[TAG_LO +: TAG_W] == PFX_TAG);
    pfx_kind  = aug_kind_e'(insn[KIND_BIT]);
    payload   = insn[AUG_W-1:0];
    use_imm[KIND_SRC] = !is_prefix && insn[SIMM_BIT];
    use_imm[KIND_DST] = !is_prefix && insn[DIMM_BIT];
    field_s   = insn[S_LO +: IMM_W];
    field_d   = insn[D_LO +: IMM_W];
  end
endmodule

// File: rtl/imm_aug_queue.sv
module imm_aug_queue
  import imm_aug_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             consume,
  input  logic [AUG_W-1:0] load_data,
  output logic             pend,
  output logic [AUG_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      data <= '0;
    end else if (load) begin
      pend <= 1'b1;
      data <= load_data;
    end else if (consume) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/imm_aug_join.sv
module imm_aug_join
  import imm_aug_pkg::*;
(
  input  logic              use_imm,
  input  logic              pend,
  input  logic [AUG_W-1:0]  data,
  input  logic [IMM_W-1:0]  field,
  output logic [WORD_W-1:0] operand
);
  always_comb begin
    operand = {((use_imm && pend) ? data : {AUG_W{1'b0}}), field};
  end
endmodule

// File: rtl/imm_aug_unit.sv
module imm_aug_unit
  import imm_aug_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_insn,
  input  logic              in_c,
  input  logic              in_z,
  input  logic              in_skip,
  output logic              out_valid,
  output logic              out_exec,
  output logic              out_ret,
  output logic              out_is_prefix,
  output logic [WORD_W-1:0] out_src,
  output logic [WORD_W-1:0] out_dst
);
  logic              exec, ret;
  logic              is_prefix;
  aug_kind_e         pfx_kind;
  logic [AUG_W-1:0]  payload;
  logic [N_KIND-1:0] use_imm;
  logic [IMM_W-1:0]  field_s, field_d;
  logic [IMM_W-1:0]  fields  [N_KIND];
  logic [N_KIND-1:0] q_pend;
  logic [AUG_W-1:0]  q_data  [N_KIND];
  logic [WORD_W-1:0] operand [N_KIND];

  imm_aug_cond u_cond (
    .cond   (in_insn[COND_LO +: COND_W]),
    .c_flag (in_c),
    .z_flag (in_z),
    .skip   (in_skip),
    .exec   (exec),
    .ret    (ret)
  );

  imm_aug_decode u_dec (
    .insn      (in_insn),
    .is_prefix (is_prefix),
    .pfx_kind  (pfx_kind),
    .payload   (payload),
    .use_imm   (use_imm),
    .field_s   (field_s),
    .field_d   (field_d)
  );

  assign fields[KIND_SRC] = field_s;
  assign fields[KIND_DST] = field_d;

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    logic do_load, do_consume;
    assign do_load    = in_valid && exec && is_prefix && (pfx_kind == aug_kind_e'(k));
    assign do_consume = in_valid && exec && use_imm[k];

    imm_aug_queue u_q (
      .clk       (clk),
      .rst       (rst),
      .load      (do_load),
      .consume   (do_consume),
      .load_data (payload),
      .pend      (q_pend[k]),
      .data      (q_data[k])
    );

    imm_aug_join u_join (
      .use_imm (use_imm[k]),
      .pend    (q_pend[k]),
      .data    (q_data[k]),
      .field   (fields[k]),
      .operand (operand[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_exec      <= 1'b0;
      out_ret       <= 1'b0;
      out_is_prefix <= 1'b0;
      out_src       <= '0;
      out_dst       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_exec      <= exec;
        out_ret       <= ret;
        out_is_prefix <= is_prefix;
        out_src       <= operand[KIND_SRC];
        out_dst       <= operand[KIND_DST];
      end
    end
  end
endmodule

// File: rtl/imm_aug_unit_chk.sv
module imm_aug_unit_chk
  import imm_aug_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_insn,
  input logic              in_skip,
  input logic              out_valid,
  input logic              out_exec,
  input logic              out_ret,
  input logic              out_is_prefix,
  input logic [WORD_W-1:0] out_src,
  input logic              src_pend,
  input logic [AUG_W-1:0]  src_data
);
  logic pfx_in, src_cons;
  assign pfx_in   = in_insn[TAG_LO +: TAG_W] == PFX_TAG;
  assign src_cons = in_valid && !pfx_in && in_insn[SIMM_BIT];

  // R1: result idle in the cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R12: one result per presented word, one clock later
  assert_latency_valid_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_latency_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2: prefix tag flagged at the output
  assert_prefix_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pfx_in) |=> out_is_prefix);

  // R3: low bits pass through, high bits come from the queue
  assert_src_low_R3: assert property (@(posedge clk) disable iff (rst)
    src_cons |=> out_src[IMM_W-1:0] == $past(in_insn[IMM_W-1:0]));
  assert_src_high_R3: assert property (@(posedge clk) disable iff (rst)
    (src_cons && src_pend) |=> out_src[WORD_W-1:IMM_W] == $past(src_data));
  assert_src_consumed_R3: assert property (@(posedge clk) disable iff (rst)
    src_cons |=> (out_exec -> !src_pend));

  // R5: non-consumers keep a pending source payload
  assert_src_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (src_pend && !src_cons) |=> src_pend);

  // R9: cancelled consumer leaves the queue pending
  assert_cancel_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (src_pend && src_cons) |=> (!out_exec -> src_pend));

  // R8: skipped words never execute
  assert_skip_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_skip) |=> !out_exec);

  // R10: return code always executes when not skipped
  assert_ret_exec_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_skip && in_insn[COND_LO +: COND_W] == COND_RET) |=> (out_exec && out_ret));
endmodule

bind imm_aug_unit imm_aug_unit_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_insn       (in_insn),
  .in_skip       (in_skip),
  .out_valid     (out_valid),
  .out_exec      (out_exec),
  .out_ret       (out_ret),
  .out_is_prefix (out_is_prefix),
  .out_src       (out_src),
  .src_pend      (q_pend[0]),
  .src_data      (q_data[0])
);

// File: tb/imm_aug_unit_bench.sv
`timescale 1ns/1ps
module imm_aug_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic        in_c = 1'b0, in_z = 1'b0, in_skip = 1'b0;
  logic        out_valid, out_exec, out_ret, out_is_prefix;
  logic [31:0] out_src, out_dst;

  always #2 clk = ~clk;

  imm_aug_unit u_imm_aug_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_c(in_c), .in_z(in_z), .in_skip(in_skip),
    .out_valid(out_valid), .out_exec(out_exec), .out_ret(out_ret),
    .out_is_prefix(out_is_prefix), .out_src(out_src), .out_dst(out_dst)
  );

  typedef struct packed {
    logic        ex;
    logic        rt;
    logic        pf;
    logic [31:0] s;
    logic [31:0] d;
  } exp_t;

  exp_t  sb_q  [$];
  string tag_q [$];
  int    n_run = 0;
  int    n_fail = 0;

  // Bench-side model state built from the requirements
  logic        m_pend [2];
  logic [22:0] m_data [2];

  function automatic logic [31:0] mk_op(input logic [3:0] cond, input logic dimm,
      input logic simm, input logic [8:0] d, input logic [8:0] s);
    return {cond, 8'h25, dimm, simm, d, s};
  endfunction

  function automatic logic [31:0] mk_pfx(input logic [3:0] cond, input logic kind,
      input logic [22:0] pay);
    return {cond, 4'hF, kind, pay};
  endfunction

  task automatic issue(input logic [31:0] w, input logic c, input logic z,
      input logic sk, input string tag);
    exp_t e;
    logic pre, pass, ex;
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_c = c; in_z = z; in_skip = sk;
    pre  = (w[27:24] == 4'hF);
    pass = (w[31:28] == 4'b0000) || w[28 + {c, z}];
    ex   = pass && !sk;
    e.ex = ex;
    e.rt = (w[31:28] == 4'b0000);
    e.pf = pre;
    e.s  = {((!pre && w[18] && m_pend[0]) ? m_data[0] : 23'd0), w[8:0]};
    e.d  = {((!pre && w[19] && m_pend[1]) ? m_data[1] : 23'd0), w[17:9]};
    if (ex && pre) begin
      m_pend[w[23]] = 1'b1;
      m_data[w[23]] = w[22:0];
    end else if (ex) begin
      if (w[18]) m_pend[0] = 1'b0;
      if (w[19]) m_pend[1] = 1'b0;
    end
    @(posedge clk);
    sb_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_skip = 1'b0;
    end
  endtask

  // Monitor: compares every registered result against the scoreboard
  exp_t  mon_e;
  string mon_t;
  always @(negedge clk) begin
    if (!rst) begin
      if (sb_q.size() > 0) begin
        mon_e = sb_q.pop_front();
        mon_t = tag_q.pop_front();
        n_run++;
        if (!out_valid || out_exec !== mon_e.ex || out_ret !== mon_e.rt ||
            out_is_prefix !== mon_e.pf || out_src !== mon_e.s || out_dst !== mon_e.d) begin
          n_fail++;
          $display("FAIL %s: got v=%b ex=%b rt=%b pf=%b src=%h dst=%h, expected v=1 ex=%b rt=%b pf=%b src=%h dst=%h",
                   mon_t, out_valid, out_exec, out_ret, out_is_prefix, out_src, out_dst,
                   mon_e.ex, mon_e.rt, mon_e.pf, mon_e.s, mon_e.d);
        end
      end else if (out_valid) begin
        n_run++;
        n_fail++;
        $display("FAIL R12: got out_valid=1 with no instruction issued, expected 0");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got run still active, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_pend[0] = 1'b0; m_pend[1] = 1'b0;
    m_data[0] = '0;   m_data[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got out_valid=%b, expected 0", out_valid);
    end

    // R1: consumer right after reset sees empty queues
    issue(mk_op(4'hF, 1'b1, 1'b1, 9'h1A5, 9'h0C3), 0, 0, 0, "R1");
    // R2 / R3: source prefix, consumer, then a second consumer with empty queue
    issue(mk_pfx(4'hF, 1'b0, 23'h12345), 0, 0, 0, "R2");
    issue(mk_op(4'hF, 1'b0, 1'b1, 9'h011, 9'h0AB), 0, 0, 0, "R3");
    issue(mk_op(4'hF, 1'b0, 1'b1, 9'h011, 9'h1FF), 0, 0, 0, "R3");
    // R4: destination prefix then destination consumer
    issue(mk_pfx(4'hF, 1'b1, 23'h7ABCDE), 0, 0, 0, "R2");
    issue(mk_op(4'hF, 1'b1, 1'b0, 9'h155, 9'h003), 0, 0, 0, "R4");
    // R5 / R11: payload survives register and other-kind instructions
    issue(mk_pfx(4'hF, 1'b0, 23'h400001), 0, 0, 0, "R2");
    issue(mk_op(4'hF, 1'b0, 1'b0, 9'h0F0, 9'h10F), 0, 0, 0, "R11");
    issue(mk_op(4'hF, 1'b1, 1'b0, 9'h022, 9'h033), 0, 0, 0, "R5");
    issue(mk_op(4'hF, 1'b0, 1'b1, 9'h000, 9'h1C1), 0, 0, 0, "R5");
    idle(2);
    // R6: both pending, one word consumes both
    issue(mk_pfx(4'hF, 1'b0, 23'h0AAAAA), 0, 0, 0, "R6");
    issue(mk_pfx(4'hF, 1'b1, 23'h555555), 0, 0, 0, "R6");
    issue(mk_op(4'hF, 1'b1, 1'b1, 9'h101, 9'h0FE), 0, 0, 0, "R6");
    // R7: second prefix replaces the first
    issue(mk_pfx(4'hF, 1'b0, 23'h111111), 0, 0, 0, "R7");
    issue(mk_pfx(4'hF, 1'b0, 23'h222222), 0, 0, 0, "R7");
    issue(mk_op(4'hF, 1'b0, 1'b1, 9'h000, 9'h077), 0, 0, 0, "R7");
    // R8: truth-table condition 4'b0100 passes only for {c,z}=2
    issue(mk_op(4'b0100, 1'b0, 1'b0, 9'h001, 9'h002), 1, 0, 0, "R8");
    issue(mk_op(4'b0100, 1'b0, 1'b0, 9'h001, 9'h002), 0, 0, 0, "R8");
    issue(mk_op(4'b0100, 1'b0, 1'b0, 9'h001, 9'h002), 1, 1, 0, "R8");
    // R9: cancelled consumers keep the queue, cancelled prefix loads nothing
    issue(mk_pfx(4'hF, 1'b0, 23'h3C3C3C), 0, 0, 0, "R9");
    issue(mk_op(4'b0001, 1'b0, 1'b1, 9'h000, 9'h044), 1, 1, 0, "R9");
    issue(mk_op(4'hF, 1'b0, 1'b1, 9'h000, 9'h045), 0, 0, 1, "R9");
    issue(mk_op(4'hF, 1'b0, 1'b1, 9'h000, 9'h046), 0, 0, 0, "R9");
    issue(mk_pfx(4'hF, 1'b1, 23'h6F6F6F), 0, 0, 1, "R9");
    issue(mk_op(4'hF, 1'b1, 1'b0, 9'h099, 9'h000), 0, 0, 0, "R9");
    // R10: return code still applies and consumes the augmentation
    issue(mk_pfx(4'hF, 1'b1, 23'h008000), 0, 0, 0, "R10");
    issue(mk_op(4'b0000, 1'b1, 1'b0, 9'h000, 9'h000), 0, 1, 0, "R10");
    issue(mk_op(4'hF, 1'b1, 1'b0, 9'h000, 9'h000), 0, 0, 0, "R10");
    idle(3);

    n_run++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12: got %0d results outstanding, expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule